// File: doc/BRIEF.md
# Fetch Return Instruction Unpacker

This block sits between the instruction memory return path and the per-wavefront instruction buffers of a compute unit. A return starts with a header carrying the owning wavefront slot and a byte count. The 32-bit words of the payload then follow, one per cycle. The block walks the words in order and turns them into buffer entries. A word with its length bit clear is a complete 32-bit instruction. A word with its length bit set opens a 64-bit instruction: it is held, and the next word closes it. Each instruction, short or long, becomes exactly one push towards the buffer. Each push carries a running sequence tag.

A wavefront that has been redirected while its fetch was in flight has its discard flag raised through a redirect input. When a return arrives for a flagged wavefront, every word is consumed and thrown away and no push is made. The flag is then lowered. At the end of every return, whether it was discarded or not, the block raises a one-cycle completion pulse that names the slot. The owner uses this pulse to clear the wavefront's fetch-in-flight state.

Top module: `fetch_unpack`

## Requirements
- R1: After reset, hdr_ready is 1, word_ready, push_valid and done_valid are 0, every bit of drop_flags is 0, and the first push carries push_seq 0.
- R2: A header is taken only while hdr_ready is 1, which is while no return is in progress. word_ready is 1 only while a return is in progress and still has words to take, so hdr_ready is 0 whenever word_ready is 1.
- R3: A return takes exactly hdr_bytes/4 words; hdr_bytes[1:0] is ignored. done_valid is 1 for exactly one cycle: the cycle after the last word is taken, or the cycle after the header when the return has no words. In that cycle done_slot equals the header slot. hdr_ready is 1 again in the next cycle.
- R4: A taken word with bit 31 clear, in a return that is not discarded and with no held first half, is pushed in the same cycle. The push has push_long 0, push_inst[31:0] equal to the word, and push_inst[63:32] equal to 0.
- R5: A taken word with bit 31 set, with no held first half and not in the last word slot, makes no push and is held. The next taken word is pushed with push_long 1 and push_inst equal to {second word, first word}. Bit 31 of that second word is not interpreted.
- R6: A word with bit 31 set taken in the last word slot of a return, with no held first half, is discarded without a push.
- R7: A rising redirect strobe for a slot sets that slot's drop_flags bit. A return whose slot flag is set when its header is taken makes no push and does not advance the sequence tag. Its completion pulse has done_dropped 1, and the flag reads 0 from the cycle after that pulse.
- R8: Pushes carry consecutive push_seq values, each one greater than the previous modulo 2^SEQ_W.
- R9: In a return that is not discarded, word_ready is 0 while push_ready is 0. A discarded return takes words regardless of push_ready.
- R10: If a redirect for a slot arrives in the same cycle that a discarded return for that slot completes, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Return header present |
| hdr_slot | input | SLOT_W | Owning wavefront slot |
| hdr_bytes | input | BYTES_W | Return size in bytes |
| hdr_ready | output | 1 | Header can be taken (no return in progress) |
| word_valid | input | 1 | Payload word present |
| word_data | input | 32 | Payload word |
| word_ready | output | 1 | Payload word taken this cycle when valid |
| push_ready | input | 1 | Target buffer can take an entry |
| push_valid | output | 1 | Buffer entry strobe |
| push_slot | output | SLOT_W | Buffer to write |
| push_inst | output | 64 | Instruction bits, second word high |
| push_long | output | 1 | Entry is a 64-bit instruction |
| push_seq | output | SEQ_W | Sequence tag of the entry |
| redir_valid | input | 1 | Redirect strobe, raises a discard flag |
| redir_slot | input | SLOT_W | Slot being redirected |
| drop_flags | output | NUM_WAVES | Current discard flags, one per slot |
| done_valid | output | 1 | Return completion pulse |
| done_slot | output | SLOT_W | Slot whose return completed |
| done_dropped | output | 1 | Completed return was discarded |

## Verification
The hardest case to reach from the ports is a redirect that lands in the exact cycle when a discarded return for the same slot completes. In that cycle the set and clear of one flag collide. The bench reaches it with a zero-length discarded return, whose completion falls in the fixed cycle right after the header, and it drives the redirect strobe in that cycle. A further hard case is a 64-bit opener in the final word slot. The bench reaches it by sizing the byte count so that the opener is the last word.

// File: rtl/fetch_unpack_pkg.sv
package fetch_unpack_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SHORT = 2'd1,
    ACT_HEAD  = 2'd2,
    ACT_TAIL  = 2'd3
  } word_act_e;

  // Decide what a taken word means for the buffer.
  function automatic word_act_e classify(input logic discard,
                                         input logic holding,
                                         input logic len_bit,
                                         input logic last_slot);
    if (discard)        return ACT_NONE;
    if (holding)        return ACT_TAIL;
    if (!len_bit)       return ACT_SHORT;
    if (last_slot)      return ACT_NONE;
    return ACT_HEAD;
  endfunction

endpackage

// File: rtl/fetch_unpack_drops.sv
module fetch_unpack_drops #(
  parameter int NUM_WAVES = 8,
  parameter int SLOT_W    = $clog2(NUM_WAVES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_valid,
  input  logic [SLOT_W-1:0]    set_slot,
  input  logic                 clr_valid,
  input  logic [SLOT_W-1:0]    clr_slot,
  output logic [NUM_WAVES-1:0] flags
);

  for (genvar i = 0; i < NUM_WAVES; i++) begin : g_flag
    logic set_hit, clr_hit, flag_q;
    assign set_hit = set_valid && (set_slot == SLOT_W'(i));
    assign clr_hit = clr_valid && (clr_slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_hit) flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit |=> flags[i]);  // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !set_hit) |=> !flags[i]);  // R7
  end

endmodule

// File: rtl/fetch_unpack_seq.sv
module fetch_unpack_seq #(
  parameter int SEQ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SEQ_W-1:0] seq
);

  function automatic logic [SEQ_W-1:0] next_tag(input logic [SEQ_W-1:0] t);
    return t + SEQ_W'(1);
  endfunction

  logic [SEQ_W-1:0] seq_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    seq_q <= '0;
    else if (step) seq_q <= next_tag(seq_q);
  end
  assign seq = seq_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (seq == SEQ_W'($past(seq) + SEQ_W'(1))));  // R8
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(seq));  // R8

endmodule

// File: rtl/fetch_unpack_scan.sv
module fetch_unpack_scan
  import fetch_unpack_pkg::*;
#(
  parameter int NUM_WAVES = 8,
  parameter int SLOT_W    = $clog2(NUM_WAVES),
  parameter int BYTES_W   = 8,
  parameter int LEN_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [SLOT_W-1:0] hdr_slot,
  input  logic [BYTES_W-1:0] hdr_bytes,
  input  logic              hdr_discard,
  output logic              hdr_ready,
  input  logic              word_valid,
  input  logic [31:0]       word_data,
  output logic              word_ready,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [63:0]       push_inst,
  output logic              push_long,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              done_valid,
  output logic              done_dropped
);

  localparam int CNT_W = BYTES_W - 2;

  function automatic logic [CNT_W-1:0] word_slots(input logic [BYTES_W-1:0] b);
    return b[BYTES_W-1:2];
  endfunction

  logic              busy_q, drop_q, hold_q;
  logic [31:0]       held_q;
  logic [CNT_W-1:0]  left_q;
  logic [SLOT_W-1:0] slot_q;

  logic      hdr_take, word_take, last_slot;
  word_act_e act;

  assign hdr_ready  = !busy_q;
  assign hdr_take   = hdr_valid && hdr_ready;
  assign last_slot  = (left_q == CNT_W'(1));
  assign word_ready = busy_q && (left_q != '0) && (drop_q || push_ready);
  assign word_take  = word_valid && word_ready;
  assign act        = classify(drop_q, hold_q, word_data[LEN_BIT], last_slot);

  assign push_valid = word_take && ((act == ACT_SHORT) || (act == ACT_TAIL));
  assign push_long  = (act == ACT_TAIL);
  assign push_inst  = (act == ACT_TAIL) ? {word_data, held_q} : {32'd0, word_data};
  assign cur_slot   = slot_q;

  assign done_valid   = busy_q && (left_q == '0);
  assign done_dropped = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      hold_q <= 1'b0;
      held_q <= '0;
      left_q <= '0;
      slot_q <= '0;
    end else begin
      if (hdr_take) begin
        busy_q <= 1'b1;
        drop_q <= hdr_discard;
        hold_q <= 1'b0;
        left_q <= word_slots(hdr_bytes);
        slot_q <= hdr_slot;
      end else if (done_valid) begin
        busy_q <= 1'b0;
      end
      if (word_take) begin
        left_q <= left_q - CNT_W'(1);
        if (act == ACT_HEAD) begin
          hold_q <= 1'b1;
          held_q <= word_data;
        end else if (act == ACT_TAIL) begin
          hold_q <= 1'b0;
        end
      end
    end
  end

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !hdr_ready);  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && hdr_ready));  // R3
  AST_NO_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && drop_q) |-> !push_valid);  // R7
  AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_ready);  // R9
  AST_NO_HOLD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !hold_q);  // R6

endmodule

// File: rtl/fetch_unpack.sv
module fetch_unpack #(
  parameter int NUM_WAVES = 8,
  parameter int SLOT_W    = $clog2(NUM_WAVES),
  parameter int BYTES_W   = 8,
  parameter int SEQ_W     = 12,
  parameter int LEN_BIT   = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  input  logic [SLOT_W-1:0]    hdr_slot,
  input  logic [BYTES_W-1:0]   hdr_bytes,
  output logic                 hdr_ready,
  input  logic                 word_valid,
  input  logic [31:0]          word_data,
  output logic                 word_ready,
  input  logic                 push_ready,
  output logic                 push_valid,
  output logic [SLOT_W-1:0]    push_slot,
  output logic [63:0]          push_inst,
  output logic                 push_long,
  output logic [SEQ_W-1:0]     push_seq,
  input  logic                 redir_valid,
  input  logic [SLOT_W-1:0]    redir_slot,
  output logic [NUM_WAVES-1:0] drop_flags,
  output logic                 done_valid,
  output logic [SLOT_W-1:0]    done_slot,
  output logic                 done_dropped
);

  logic              hdr_discard, clear_flag;
  logic [SLOT_W-1:0] cur_slot;

  assign hdr_discard = drop_flags[hdr_slot];
  assign clear_flag  = done_valid && done_dropped;
  assign push_slot   = cur_slot;
  assign done_slot   = cur_slot;

  fetch_unpack_drops #(.NUM_WAVES(NUM_WAVES), .SLOT_W(SLOT_W)) u_drops (
    .clk(clk), .rst_n(rst_n),
    .set_valid(redir_valid), .set_slot(redir_slot),
    .clr_valid(clear_flag), .clr_slot(cur_slot),
    .flags(drop_flags)
  );

  fetch_unpack_scan #(.NUM_WAVES(NUM_WAVES), .SLOT_W(SLOT_W),
                      .BYTES_W(BYTES_W), .LEN_BIT(LEN_BIT)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_slot(hdr_slot), .hdr_bytes(hdr_bytes),
    .hdr_discard(hdr_discard), .hdr_ready(hdr_ready),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .push_ready(push_ready), .push_valid(push_valid), .push_inst(push_inst),
    .push_long(push_long), .cur_slot(cur_slot),
    .done_valid(done_valid), .done_dropped(done_dropped)
  );

  fetch_unpack_seq #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(push_valid), .seq(push_seq)
  );

  AST_DONE_NAMES_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_dropped) |-> drop_flags[done_slot]);  // R7

endmodule

// File: tb/fetch_unpack_tb.sv
module fetch_unpack_tb;
  localparam int NW = 8;
  localparam int SW = 3;
  localparam int BW = 8;
  localparam int QW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [SW-1:0] hdr_slot = '0;
  logic [BW-1:0] hdr_bytes = '0;
  logic hdr_ready, word_ready, push_valid, push_long, done_valid, done_dropped;
  logic word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic push_ready = 1'b1;
  logic [SW-1:0] push_slot, done_slot;
  logic [63:0] push_inst;
  logic [QW-1:0] push_seq;
  logic redir_valid = 1'b0;
  logic [SW-1:0] redir_slot = '0;
  logic [NW-1:0] drop_flags;

  always #10 clk = ~clk;

  fetch_unpack #(.NUM_WAVES(NW), .BYTES_W(BW), .SEQ_W(QW), .LEN_BIT(31)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_slot(hdr_slot), .hdr_bytes(hdr_bytes), .hdr_ready(hdr_ready),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .push_ready(push_ready), .push_valid(push_valid), .push_slot(push_slot),
    .push_inst(push_inst), .push_long(push_long), .push_seq(push_seq),
    .redir_valid(redir_valid), .redir_slot(redir_slot), .drop_flags(drop_flags),
    .done_valid(done_valid), .done_slot(done_slot), .done_dropped(done_dropped)
  );

  int total = 0;
  int bad = 0;
  int seq_next = 0;

  logic [31:0] words_mem [64];
  logic [63:0] exp_inst [64];
  logic        exp_long [64];
  int          exp_n;
  logic [63:0] obs_inst [64];
  logic        obs_long [64];
  logic [QW-1:0] obs_seq [64];
  logic [SW-1:0] obs_slot [64];
  int          obs_n = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (push_valid && obs_n < 64) begin
      obs_inst[obs_n] = push_inst;
      obs_long[obs_n] = push_long;
      obs_seq[obs_n]  = push_seq;
      obs_slot[obs_n] = push_slot;
      obs_n++;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Independent model of the expected entries.
  task automatic build_exp(input int nw, input bit drop);
    int i = 0;
    exp_n = 0;
    if (!drop) begin
      while (i < nw) begin
        if (words_mem[i][31] == 1'b0) begin
          exp_inst[exp_n] = {32'd0, words_mem[i]}; exp_long[exp_n] = 1'b0; exp_n++; i++;
        end else if (i + 1 < nw) begin
          exp_inst[exp_n] = {words_mem[i+1], words_mem[i]}; exp_long[exp_n] = 1'b1; exp_n++; i += 2;
        end else begin
          i++;
        end
      end
    end
  endtask

  task automatic pulse_redirect(input int slot);
    redir_valid = 1'b1; redir_slot = SW'(slot);
    @(posedge clk); #1;
    redir_valid = 1'b0;
  endtask

  // One whole return: header, words, completion and flag checks.
  task automatic feed(input int slot, input int nbytes, input bit stall, input bit hold_low,
                      input bit exp_drop, input bit redir_same, input string tag);
    int nw = nbytes / 4;
    build_exp(nw, exp_drop);
    obs_n = 0;
    if (hold_low) push_ready = 1'b0;
    hdr_valid = 1'b1; hdr_slot = SW'(slot); hdr_bytes = BW'(nbytes);
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    if (redir_same) begin redir_valid = 1'b1; redir_slot = SW'(slot); end
    for (int i = 0; i < nw; i++) begin
      word_valid = 1'b1; word_data = words_mem[i];
      if (stall) begin
        push_ready = 1'b0;
        @(negedge clk);
        check(word_ready == 1'b0, {tag, " R9 stall"}, 64'(word_ready), 64'(0));
        @(posedge clk); #1;
        push_ready = 1'b1;
      end
      @(negedge clk);
      if (i == 0) check(hdr_ready == 1'b0, {tag, " R2 busy"}, 64'(hdr_ready), 64'(0));
      while (!word_ready) begin @(posedge clk); @(negedge clk); end
      @(posedge clk); #1;
    end
    word_valid = 1'b0;
    @(negedge clk);
    check(done_valid == 1'b1, {tag, " R3 done"}, 64'(done_valid), 64'(1));
    check(done_slot == SW'(slot), {tag, " R3 slot"}, 64'(done_slot), 64'(slot));
    check(done_dropped == exp_drop, {tag, " R7 dropped"}, 64'(done_dropped), 64'(exp_drop));
    @(posedge clk); #1;
    redir_valid = 1'b0;
    push_ready = 1'b1;
    @(negedge clk);
    check(done_valid == 1'b0 && hdr_ready == 1'b1, {tag, " R3 end"}, 64'({done_valid, hdr_ready}), 64'(1));
    if (exp_drop)
      check(drop_flags[slot] == redir_same, {tag, " R7/R10 flag after"}, 64'(drop_flags[slot]), 64'(redir_same));
    check(obs_n == exp_n, {tag, " R4/R5 push count"}, 64'(obs_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < obs_n; k++) begin
      check(obs_inst[k] == exp_inst[k], {tag, " R4/R5 inst"}, obs_inst[k], exp_inst[k]);
      check(obs_long[k] == exp_long[k], {tag, " R5 long"}, 64'(obs_long[k]), 64'(exp_long[k]));
      check(obs_seq[k] == QW'(seq_next + k), {tag, " R8 seq"}, 64'(obs_seq[k]), 64'(QW'(seq_next + k)));
      check(obs_slot[k] == SW'(slot), {tag, " push slot"}, 64'(obs_slot[k]), 64'(slot));
    end
    seq_next += exp_n;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(hdr_ready == 1'b1, "R1 hdr_ready", 64'(hdr_ready), 64'(1));
    check(word_ready == 1'b0 && push_valid == 1'b0 && done_valid == 1'b0, "R1 strobes",
          64'({word_ready, push_valid, done_valid}), 64'(0));
    check(drop_flags == '0, "R1 flags", 64'(drop_flags), 64'(0));
    check(push_seq == '0, "R1 seq", 64'(push_seq), 64'(0));
  endtask

  task automatic t_short;
    for (int i = 0; i < 4; i++) words_mem[i] = 32'h1000_0000 + 32'(i * 17);
    feed(1, 16, 1'b0, 1'b0, 1'b0, 1'b0, "short R4");
  endtask

  task automatic t_mixed;
    words_mem[0] = 32'h0000_00a1;
    words_mem[1] = 32'h8000_00b2; words_mem[2] = 32'h1234_5678;
    words_mem[3] = 32'h7fff_ffff;
    words_mem[4] = 32'hc0de_0001; words_mem[5] = 32'h8765_4321;  // tail has bit 31 set
    words_mem[6] = 32'h0000_0042;
    feed(3, 28, 1'b0, 1'b0, 1'b0, 1'b0, "mixed R5");
  endtask

  task automatic t_orphan;
    words_mem[0] = 32'h0000_0011; words_mem[1] = 32'h8000_0022;
    feed(4, 8, 1'b0, 1'b0, 1'b0, 1'b0, "orphan R6");
  endtask

  task automatic t_sizes;
    feed(0, 3, 1'b0, 1'b0, 1'b0, 1'b0, "zero R3");
    words_mem[0] = 32'h0000_0aaa; words_mem[1] = 32'h0000_0bbb;
    feed(7, 10, 1'b0, 1'b0, 1'b0, 1'b0, "lowbits R3");
  endtask

  task automatic t_drop;
    pulse_redirect(5);
    @(negedge clk);
    check(drop_flags[5] == 1'b1 && drop_flags[4] == 1'b0, "R7 set", 64'(drop_flags), 64'(8'h20));
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) words_mem[i] = 32'h0000_0100 + 32'(i);
    feed(5, 12, 1'b0, 1'b1, 1'b1, 1'b0, "drop R7 R9");
    words_mem[0] = 32'h0000_0333;
    feed(5, 4, 1'b0, 1'b0, 1'b0, 1'b0, "after drop R7");
  endtask

  task automatic t_stall;
    words_mem[0] = 32'h0000_0777; words_mem[1] = 32'h8000_0888; words_mem[2] = 32'h0000_0999;
    feed(2, 12, 1'b1, 1'b0, 1'b0, 1'b0, "stall R9");
  endtask

  task automatic t_collide;
    pulse_redirect(6);
    pulse_redirect(1);
    feed(6, 0, 1'b0, 1'b0, 1'b1, 1'b1, "collide R10");
    words_mem[0] = 32'h0000_0555;
    feed(6, 4, 1'b0, 1'b0, 1'b1, 1'b0, "second drop R10");
    check(drop_flags[1] == 1'b1, "R10 other slot", 64'(drop_flags[1]), 64'(1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    t_short();
    t_mixed();
    t_orphan();
    t_sizes();
    t_drop();
    t_stall();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule